// File: doc/BRIEF.md
# Oversampling Serial Frame Receiver

This block receives asynchronous serial frames on a single line that idles high. A falling edge on the line, seen after a two-stage synchronizer, opens a frame. From then on one running oversample counter, advanced by an integer divider of the system clock, times the whole frame. It is not reset at each bit. Every bit is sampled at the instant the counter steps from 16N+7 to 16N+8, which is the nominal centre of bit N.

The frame is a start bit, eight data bits with the least significant first, one parity bit and one stop bit. The received byte is presented with a one-clock valid strobe and two error flags. The divider rounds the ideal ratio to a whole number of clocks, so the sample points drift against the true bit centres as the frame goes on. This drift is accepted and can be seen on the exposed frame counter.

The received byte leaves the block as a stream with no ready input. A serial line cannot be stalled, so there is no back-pressure. A consumer must take `data_o` in the cycle `data_valid_o` is high, or at any time before the next valid, because the byte is held until then.

Top module: `uart_frame_rx`

## Requirements
- R1: While `rst_n` is low and after it rises, `data_o`, `data_valid_o`, `parity_err_o`, `frame_err_o` and `frame_cnt_o` are all zero.
- R2: A high-to-low transition of `rxd_i` in idle starts a frame. The divider is `round(CLK_HZ/(BAUD*16))` clocks, which is 27 by default. `frame_cnt_o` advances by exactly one per divider period. Take an edge driven between two clock edges; 1000 clocks later, `frame_cnt_o` reads 36.
- R3: Bit N of the frame (start is N=0) is sampled when the counter steps from 16N+7 to 16N+8. Bits 1 to 8 build `data_o` least significant bit first.
- R4: Parity is even by default: the eight data bits and the parity bit hold an even number of ones. `parity_err_o` is 1 when they do not.
- R5: `frame_err_o` is 1 when the stop bit (N=10) samples low.
- R6: `data_valid_o` is high for exactly one clock, at the stop-bit sample. `data_o`, `parity_err_o` and `frame_err_o` change only in that cycle and hold their values until the next one.
- R7: If the start bit samples high at its centre, the frame is dropped: no valid pulse, and the block returns to idle.
- R8: `frame_cnt_o` is 0 whenever the block is idle, including the cycle of the valid pulse and after a dropped frame. It never exceeds 176.
- R9: A new start edge that arrives right after a stop bit is received as a new frame, with no idle gap needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Asynchronous serial line, idle high |
| data_o | output | 8 | Last received byte |
| data_valid_o | output | 1 | One-clock strobe for a completed frame |
| parity_err_o | output | 1 | Parity mismatch in the last frame |
| frame_err_o | output | 1 | Stop bit sampled low in the last frame |
| frame_cnt_o | output | 8 | Running oversample counter of the frame, 0 in idle |

## Verification
The hardest situation to reach from the ports is the dropped start: the line has to fall and then rise again before the counter reaches its first centre crossing, and nothing on the outputs changes as a result. The stimulus drives a 50-clock low pulse. After the point where the start sample would fall, it confirms that the counter is back at zero and that no valid pulse has appeared. It then sends a normal frame, to show that the receiver has recovered. Drift is exercised by driving frames at the true bit time of 434 clocks against the 27-clock divider, so the stop sample lands well off centre.

// File: rtl/uart_frame_rx_pkg.sv
package uart_frame_rx_pkg;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  // Rounded integer ratio of system clock to oversample rate.
  function automatic int calc_div(input longint clk_hz, input longint baud, input int ovs);
    longint rate;
    rate = baud * ovs;
    return int'((clk_hz + rate / 2) / rate);
  endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain;
  logic              line_d;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= line_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_d <= 1'b1;
    else        line_d <= chain[STAGES-1];
  end

  assign line_s_o = chain[STAGES-1];
  assign fall_o   = line_d & ~chain[STAGES-1];

endmodule

// File: rtl/rx_tick_div.sv
module rx_tick_div #(
  parameter int DIV = 27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);

  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear_i || !run_i) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick_o = run_i && !clear_i && (cnt == LAST);

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import uart_frame_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVS        = 16,
  parameter bit PARITY_ODD = 1'b0,
  parameter int CNT_W      = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_s_i,
  input  logic                 fall_i,
  input  logic                 tick_i,
  output logic                 start_o,
  output logic                 busy_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 valid_o,
  output logic                 perr_o,
  output logic                 ferr_o,
  output logic [CNT_W-1:0]     cnt_o
);

  localparam int OVS_W     = $clog2(OVS);
  localparam int IDX_W     = CNT_W - OVS_W;
  localparam int PAR_IDX   = DATA_BITS + 1;
  localparam int STOP_IDX  = DATA_BITS + 2;
  localparam logic [OVS_W-1:0] MID_PRE = OVS_W'(OVS / 2 - 1);

  rx_state_e              state;
  logic [CNT_W-1:0]       cnt;
  logic [DATA_BITS-1:0]   shreg;
  logic                   par_acc;
  logic                   at_mid;
  logic [IDX_W-1:0]       bit_idx;

  assign start_o = (state == RX_IDLE) && fall_i;
  assign busy_o  = (state == RX_BUSY);
  assign at_mid  = tick_i && (cnt[OVS_W-1:0] == MID_PRE);
  assign bit_idx = cnt[CNT_W-1:OVS_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      data_o  <= '0;
      valid_o <= 1'b0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          cnt <= '0;
          if (fall_i) begin
            state   <= RX_BUSY;
            par_acc <= 1'b0;
          end
        end
        RX_BUSY: begin
          if (tick_i) cnt <= cnt + 1'b1;
          if (at_mid) begin
            if (bit_idx == '0) begin
              if (line_s_i) begin
                state <= RX_IDLE;
                cnt   <= '0;
              end
            end else if (int'(bit_idx) <= DATA_BITS) begin
              shreg   <= {line_s_i, shreg[DATA_BITS-1:1]};
              par_acc <= par_acc ^ line_s_i;
            end else if (int'(bit_idx) == PAR_IDX) begin
              par_acc <= par_acc ^ line_s_i;
            end else if (int'(bit_idx) == STOP_IDX) begin
              data_o  <= shreg;
              perr_o  <= par_acc ^ PARITY_ODD;
              ferr_o  <= ~line_s_i;
              valid_o <= 1'b1;
              state   <= RX_IDLE;
              cnt     <= '0;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign cnt_o = cnt;

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_frame_rx_pkg::*;
#(
  parameter int  CLK_HZ      = 50_000_000,
  parameter int  BAUD        = 115_200,
  parameter int  OVS         = 16,
  parameter int  DATA_BITS   = 8,
  parameter bit  PARITY_ODD  = 1'b0,
  parameter int  SYNC_STAGES = 2,
  localparam int FRAME_BITS  = DATA_BITS + 3,
  localparam int FRAME_TICKS = FRAME_BITS * OVS,
  localparam int CNT_W       = $clog2(FRAME_TICKS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd_i,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 data_valid_o,
  output logic                 parity_err_o,
  output logic                 frame_err_o,
  output logic [CNT_W-1:0]     frame_cnt_o
);

  localparam int DIV = calc_div(longint'(CLK_HZ), longint'(BAUD), OVS);

  logic line_s;
  logic fall;
  logic tick;
  logic start;
  logic busy;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (rxd_i),
    .line_s_o (line_s),
    .fall_o   (fall)
  );

  rx_tick_div #(.DIV(DIV)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (start),
    .run_i   (busy),
    .tick_o  (tick)
  );

  rx_frame_ctrl #(
    .DATA_BITS  (DATA_BITS),
    .OVS        (OVS),
    .PARITY_ODD (PARITY_ODD),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_s_i (line_s),
    .fall_i   (fall),
    .tick_i   (tick),
    .start_o  (start),
    .busy_o   (busy),
    .data_o   (data_o),
    .valid_o  (data_valid_o),
    .perr_o   (parity_err_o),
    .ferr_o   (frame_err_o),
    .cnt_o    (frame_cnt_o)
  );

endmodule

// File: rtl/uart_frame_rx_chk.sv
module uart_frame_rx_chk #(
  parameter int DATA_BITS   = 8,
  parameter int FRAME_TICKS = 176,
  parameter int CNT_W       = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [DATA_BITS-1:0] data_o,
  input logic                 data_valid_o,
  input logic                 parity_err_o,
  input logic                 frame_err_o,
  input logic [CNT_W-1:0]     frame_cnt_o
);

  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |=> !data_valid_o);

  p_flags_move_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(parity_err_o) || !$stable(frame_err_o) || !$stable(data_o)) |-> data_valid_o);

  p_cnt_idle_at_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid_o |-> (frame_cnt_o == '0));

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(frame_cnt_o) <= FRAME_TICKS);

  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (frame_cnt_o == $past(frame_cnt_o)) ||
             (frame_cnt_o == $past(frame_cnt_o) + 1'b1) ||
             (frame_cnt_o == '0));

endmodule

bind uart_frame_rx uart_frame_rx_chk #(
  .DATA_BITS   (DATA_BITS),
  .FRAME_TICKS (FRAME_TICKS),
  .CNT_W       (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .data_o       (data_o),
  .data_valid_o (data_valid_o),
  .parity_err_o (parity_err_o),
  .frame_err_o  (frame_err_o),
  .frame_cnt_o  (frame_cnt_o)
);

// File: tb/uart_frame_rx_tb.sv
module uart_frame_rx_tb;

  localparam int CLK_PERIOD = 20;
  localparam int BIT_CLKS   = 434;
  localparam int WATCHDOG   = 200000;

  typedef struct packed {
    logic [7:0] d;
    logic       pe;
    logic       fe;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic [7:0] data;
  logic       valid;
  logic       perr;
  logic       ferr;
  logic [7:0] fcnt;

  int   n_checks = 0;
  int   n_fail   = 0;
  int   n_valid  = 0;
  bit   finished = 1'b0;
  bit   prev_valid = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_frame_rx u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .rxd_i        (rxd),
    .data_o       (data),
    .data_valid_o (valid),
    .parity_err_o (perr),
    .frame_err_o  (ferr),
    .frame_cnt_o  (fcnt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    idle_clks(BIT_CLKS);
  endtask

  // Driver: push the expected item, then drive the frame onto the line.
  task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop);
    exp_t e;
    e.d = b; e.pe = bad_par; e.fe = bad_stop;
    sb.push_back(e);
    drive_bit(1'b0);
    for (int i = 0; i < 8; i++) drive_bit(b[i]);
    drive_bit((^b) ^ bad_par);
    drive_bit(~bad_stop);
    rxd = 1'b1;
  endtask

  // Monitor: compare each completed frame with the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(!(valid && prev_valid), "R6 valid one clock", 1, 0);
      if (valid) begin
        n_valid++;
        check(fcnt == 8'd0, "R8 counter zero at valid", fcnt, 0);
        if (sb.size() == 0) begin
          check(1'b0, "R7 unexpected frame", data, -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(data == e.d, "R3 data byte", data, e.d);
          check(perr == e.pe, "R4 parity flag", perr, e.pe);
          check(ferr == e.fe, "R5 stop flag", ferr, e.fe);
        end
      end
      prev_valid = valid;
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
      finish_run();
    end
  end

  initial begin
    int v0;
    idle_clks(5);
    // R1 reset state
    check({data, valid, perr, ferr, fcnt} == '0, "R1 during reset", {data, valid, perr, ferr}, 0);
    rst_n = 1'b1;
    idle_clks(20);
    check({data, valid, perr, ferr, fcnt} == '0, "R1 after reset", fcnt, 0);

    // R2 counter rate: 1000 clocks after the edge
    fork
      send_frame(8'hA5, 1'b0, 1'b0);
      begin
        idle_clks(1000);
        check(fcnt == 8'd36, "R2 counter after 1000 clocks", fcnt, 36);
      end
    join
    idle_clks(200);
    check(data == 8'hA5, "R6 byte held after valid", data, 8'hA5);

    // R3 several patterns, R9 back-to-back (no gap after stop)
    send_frame(8'h00, 1'b0, 1'b0);
    send_frame(8'hFF, 1'b0, 1'b0);
    send_frame(8'h01, 1'b0, 1'b0);
    send_frame(8'h80, 1'b0, 1'b0);
    idle_clks(100);
    check(sb.size() == 0, "R9 back-to-back all received", sb.size(), 0);

    // R4 parity error
    send_frame(8'h3C, 1'b1, 1'b0);
    idle_clks(100);
    check(perr == 1'b1, "R4 flag held", perr, 1);
    // R5 stop error; line returns high afterwards
    send_frame(8'h5A, 1'b0, 1'b1);
    idle_clks(600);
    check(ferr == 1'b1, "R5 flag held", ferr, 1);

    // R7 glitch: short low pulse, dropped
    v0 = n_valid;
    rxd = 1'b0;
    idle_clks(50);
    rxd = 1'b1;
    idle_clks(350);
    check(fcnt == 8'd0, "R7 counter back to zero", fcnt, 0);
    idle_clks(BIT_CLKS * 12);
    check(n_valid == v0, "R7 no output after glitch", n_valid, v0);
    check(ferr == 1'b1 && data == 8'h5A, "R7 outputs untouched", data, 8'h5A);

    // Recovery frame
    send_frame(8'hC3, 1'b0, 1'b0);
    idle_clks(200);
    check(sb.size() == 0, "R3 scoreboard drained", sb.size(), 0);
    check(ferr == 1'b0 && perr == 1'b0, "R6 flags cleared by good frame", {perr, ferr}, 0);
    finish_run();
  end

endmodule